// File: doc/BRIEF.md
# Two-Level Aperture Address Translator

This block maps bus addresses that land inside a graphics aperture window onto physical page addresses. A request address is first compared against the window. The window is set by a base register and a size field. An address outside the window comes back unchanged and is flagged. An address inside it is looked up in a small translation cache. On a miss, the walker reads a directory entry and then a page-table entry through a one-outstanding memory read port, and builds the physical address from the table entry's page number and the request's page offset.

Software owns the tables and the configuration. It writes the directory base, the aperture base, the size field and the enables through a simple write-only register port. It invalidates every cached translation with a single write to the flush register. Each directory entry covers 4 MiB, and each table holds 1024 entries for 4 KiB pages. Bit 0 of every entry marks it valid.

Top module: `aper_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0, and translation is off, so a request returns its own address with rsp_nia=1.
- R2: Register byte offsets: 0x02 bit 2 enables translation. 0x04 holds the directory base byte address. 0x08 holds the size field: bit 0 enables the aperture, and bits 3:1 hold a field f that gives a window of 32 MiB << f for f = 0..6, while f = 7 gives an empty window. 0x10 holds the aperture base in bits 31:22. A request is treated as inside the window only when both enable bits are set.
- R3: A request below the aperture base, or at or beyond base plus size, returns its address unchanged with rsp_nia=1 and rsp_fault=0. It starts no memory read, and rsp_valid rises one cycle after acceptance.
- R4: The directory read address is the directory base plus 4 * (addr[31:22] - base[31:22]).
- R5: The table read address is {directory entry bits 31:12, addr[21:12], 2'b00}.
- R6: A walk with both entries valid returns {table entry bits 31:12, addr[11:0]} with rsp_fault=0 and rsp_nia=0, one cycle after the table entry arrives.
- R7: A directory or table entry with bit 0 clear ends the walk with rsp_fault=1, rsp_nia=0 and the request address unchanged. No further read is issued and nothing is cached, so the same address walks again.
- R8: A request whose 4 KiB page is cached returns its translation one cycle after acceptance with no memory read.
- R9: The cache holds 8 pages and replaces them round robin. Of 9 distinct pages filled in order after a flush, the first is evicted and the second stays cached.
- R10: Writing offset 0x0C with data bit 0 set invalidates every cached page at once. The same write with bit 0 clear changes nothing.
- R11: A flush written while a walk is in progress still lets that walk return its translation, but the result is not cached.
- R12: mem_req_valid and mem_req_addr hold steady until mem_req_ready, and only one read is outstanding at a time.
- R13: req_ready is 1 only while idle, so it is 0 in the cycle after acceptance, and rsp_valid is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 32 | Translated or unchanged address |
| rsp_fault | output | 1 | Invalid directory or table entry met |
| rsp_nia | output | 1 | Address not in the active aperture |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_addr | output | 32 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word |

## Verification
Results arrive at fixed distances from acceptance. Out-of-window and cached requests answer one cycle after the accepting edge. A full walk with an always-ready memory answers five cycles after it. A directory fault answers after three. Every stalled ready cycle adds one. The bench counts falling edges from acceptance to the first rsp_valid and compares that count with these figures. It also confirms that rsp_valid is low on the edge that follows. The number of memory reads and their addresses are sampled on the falling edge where the handshake completes, so that read counts and cache hits are checked against the same timing.

// File: rtl/aper_pkg.sv
package aper_pkg;
    localparam int AW      = 32;
    localparam int REG_AW  = 5;
    localparam int PAGE_SH = 12;
    localparam int DIR_SH  = 22;
    localparam int PN_W    = AW - PAGE_SH;
    localparam int DIR_W   = AW - DIR_SH;

    localparam logic [REG_AW-1:0] OFS_CTL   = 5'h02;
    localparam logic [REG_AW-1:0] OFS_DIR   = 5'h04;
    localparam logic [REG_AW-1:0] OFS_SIZE  = 5'h08;
    localparam logic [REG_AW-1:0] OFS_FLUSH = 5'h0C;
    localparam logic [REG_AW-1:0] OFS_BASE  = 5'h10;
    localparam int XL_EN_BIT = 2;

    typedef enum logic [1:0] {W_IDLE, W_DIR, W_TBL, W_RESP} walk_st_e;

    typedef struct packed {
        logic              xl_en;
        logic              ap_en;
        logic [2:0]        size_f;
        logic [AW-1:0]     dir_base;
        logic [DIR_W-1:0]  ap_base;
    } cfg_t;

    typedef struct packed {
        walk_st_e      st;
        logic          sent;
        logic          killed;
        logic [AW-1:0] va;
        logic [AW-1:0] maddr;
        logic [AW-1:0] raddr;
        logic          fault;
        logic          nia;
    } walk_t;

    // number of 4 MiB directory slots covered by the window
    function automatic logic [DIR_W:0] dir_count(input logic [2:0] f);
        return (f == 3'd7) ? '0 : ((DIR_W+1)'(8) << f);
    endfunction
endpackage

// File: rtl/aper_regs.sv
module aper_regs
    import aper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [AW-1:0]     wdata,
    output cfg_t              cfg,
    output logic              flush
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                OFS_CTL:  cfg_d.xl_en    = wdata[XL_EN_BIT];
                OFS_DIR:  cfg_d.dir_base = wdata;
                OFS_SIZE: begin
                    cfg_d.ap_en  = wdata[0];
                    cfg_d.size_f = wdata[3:1];
                end
                OFS_BASE: cfg_d.ap_base  = wdata[AW-1:DIR_SH];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg   = cfg_q;
    assign flush = we && (addr == OFS_FLUSH) && wdata[0];

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_CTL) |=> (cfg.xl_en == $past(wdata[XL_EN_BIT])));
endmodule

// File: rtl/aper_tlb.sv
module aper_tlb
    import aper_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PN_W-1:0] look_pn,
    output logic            hit,
    output logic [PN_W-1:0] hit_ppn,
    input  logic            fill_en,
    input  logic [PN_W-1:0] fill_pn,
    input  logic [PN_W-1:0] fill_ppn,
    input  logic            flush
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0]           vld;
        logic [DEPTH-1:0][PN_W-1:0] tag;
        logic [DEPTH-1:0][PN_W-1:0] ppn;
        logic [PTR_W-1:0]           ptr;
    } tlb_t;

    tlb_t tlb_d, tlb_q;
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = tlb_q.vld[g] && (tlb_q.tag[g] == look_pn);
    end

    always_comb begin
        hit_ppn = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) hit_ppn = hit_ppn | tlb_q.ppn[i];
        end
    end
    assign hit = |match;

    always_comb begin
        tlb_d = tlb_q;
        if (flush) begin
            tlb_d.vld = '0;
        end else if (fill_en) begin
            tlb_d.vld[tlb_q.ptr] = 1'b1;
            tlb_d.tag[tlb_q.ptr] = fill_pn;
            tlb_d.ppn[tlb_q.ptr] = fill_ppn;
            tlb_d.ptr = (tlb_q.ptr == PTR_W'(DEPTH-1)) ? '0 : tlb_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tlb_q <= '0;
        else        tlb_q <= tlb_d;
    end

    // R9
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tlb_q.vld == '0));
endmodule

// File: rtl/aper_walker.sv
module aper_walker
    import aper_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  cfg_t            cfg,
    input  logic            flush,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic            tlb_hit,
    input  logic [PN_W-1:0] tlb_ppn,
    output logic            fill_en,
    output logic [PN_W-1:0] fill_pn,
    output logic [PN_W-1:0] fill_ppn,
    output logic            rsp_valid,
    output logic [AW-1:0]   rsp_addr,
    output logic            rsp_fault,
    output logic            rsp_nia,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [AW-1:0]   mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [AW-1:0]   mem_rsp_data
);
    walk_t w_d, w_q;
    logic active, in_ap;
    logic [DIR_W:0] diff;
    logic unused_bits;

    assign unused_bits = ^mem_rsp_data[PAGE_SH-1:1];

    always_comb begin
        w_d      = w_q;
        fill_en  = 1'b0;
        fill_pn  = w_q.va[AW-1:PAGE_SH];
        fill_ppn = mem_rsp_data[AW-1:PAGE_SH];
        active   = cfg.xl_en && cfg.ap_en;
        diff     = {1'b0, req_addr[AW-1:DIR_SH]} - {1'b0, cfg.ap_base};
        in_ap    = active && !diff[DIR_W] && (diff < dir_count(cfg.size_f));
        mem_req_valid = (w_q.st == W_DIR || w_q.st == W_TBL) && !w_q.sent;

        if (flush && w_q.st != W_IDLE) w_d.killed = 1'b1;

        unique case (w_q.st)
            W_IDLE: begin
                if (req_valid) begin
                    w_d.va     = req_addr;
                    w_d.raddr  = req_addr;
                    w_d.killed = 1'b0;
                    w_d.sent   = 1'b0;
                    w_d.fault  = 1'b0;
                    w_d.nia    = 1'b0;
                    if (!in_ap) begin
                        w_d.nia = 1'b1;
                        w_d.st  = W_RESP;
                    end else if (tlb_hit) begin
                        w_d.raddr = {tlb_ppn, req_addr[PAGE_SH-1:0]};
                        w_d.st    = W_RESP;
                    end else begin
                        w_d.maddr = cfg.dir_base +
                                    {{(AW-DIR_W-2){1'b0}}, diff[DIR_W-1:0], 2'b00};
                        w_d.st    = W_DIR;
                    end
                end
            end
            W_DIR, W_TBL: begin
                if (mem_req_valid && mem_req_ready) w_d.sent = 1'b1;
                if (w_q.sent && mem_rsp_valid) begin
                    w_d.sent = 1'b0;
                    if (!mem_rsp_data[0]) begin
                        w_d.fault = 1'b1;
                        w_d.st    = W_RESP;
                    end else if (w_q.st == W_DIR) begin
                        w_d.maddr = {mem_rsp_data[AW-1:PAGE_SH],
                                     w_q.va[DIR_SH-1:PAGE_SH], 2'b00};
                        w_d.st    = W_TBL;
                    end else begin
                        w_d.raddr = {mem_rsp_data[AW-1:PAGE_SH], w_q.va[PAGE_SH-1:0]};
                        fill_en   = !(w_q.killed || flush);
                        w_d.st    = W_RESP;
                    end
                end
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign req_ready    = (w_q.st == W_IDLE);
    assign rsp_valid    = (w_q.st == W_RESP);
    assign rsp_addr     = w_q.raddr;
    assign rsp_fault    = w_q.fault;
    assign rsp_nia      = w_q.nia;
    assign mem_req_addr = w_q.maddr;

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
    // R13
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R13
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R7
    fill_only_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (rsp_valid && !rsp_fault && !rsp_nia));
    // R3
    nia_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_nia) |-> !rsp_fault);
endmodule

// File: rtl/aper_xlate.sv
module aper_xlate
    import aper_pkg::*;
#(
    parameter int TLB_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_addr,
    output logic              rsp_fault,
    output logic              rsp_nia,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [AW-1:0]     mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [AW-1:0]     mem_rsp_data
);
    cfg_t            cfg;
    logic            flush, hit, fill_en;
    logic [PN_W-1:0] hit_ppn, fill_pn, fill_ppn;

    aper_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .cfg(cfg), .flush(flush)
    );

    aper_tlb #(.DEPTH(TLB_DEPTH)) u_tlb (
        .clk(clk), .rst_n(rst_n), .look_pn(req_addr[AW-1:PAGE_SH]),
        .hit(hit), .hit_ppn(hit_ppn), .fill_en(fill_en),
        .fill_pn(fill_pn), .fill_ppn(fill_ppn), .flush(flush)
    );

    aper_walker u_walk (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .tlb_hit(hit), .tlb_ppn(hit_ppn), .fill_en(fill_en),
        .fill_pn(fill_pn), .fill_ppn(fill_ppn),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_nia(rsp_nia),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );
endmodule

// File: tb/sim_aper_xlate.sv
`timescale 1ns/1ps
module sim_aper_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_fault, rsp_nia;
    logic [31:0] rsp_addr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_chk = 0, n_bad = 0;
    int rd_n = 0, hold = 0;
    logic pend = 1'b0;
    logic [31:0] pend_a = '0;
    logic [31:0] rd_log [16];

    aper_xlate u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault), .rsp_nia(rsp_nia),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always #2.5 clk = ~clk;

    // table image: three directory slots, three tables, one bad table slot
    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        case (a)
            32'h0010_0000: return 32'h0020_0001;
            32'h0010_0004: return 32'h0030_0001;
            32'h0010_001C: return 32'h0040_0001;
            default: ;
        endcase
        if (a[31:12] == 20'h00200) return (a[11:2] == 10'd9) ? 32'h0 : {10'h280, a[11:2], 12'h001};
        if (a[31:12] == 20'h00300) return {10'h2C0, a[11:2], 12'h001};
        if (a[31:12] == 20'h00400) return {10'h300, a[11:2], 12'h001};
        return 32'h0;
    endfunction

    always @(negedge clk) begin
        mem_rsp_valid = pend;
        mem_rsp_data  = pend ? mem_rd(pend_a) : 32'hDEAD_BEEF;
        pend = 1'b0;
        if (hold > 0) begin mem_req_ready = 1'b0; hold--; end
        else mem_req_ready = 1'b1;
        if (mem_req_valid && mem_req_ready) begin
            pend = 1'b1; pend_a = mem_req_addr;
            rd_log[rd_n % 16] = mem_req_addr; rd_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); #1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1; reg_we = 1'b0;
    endtask

    // issue one request, measure latency in cycles and reads spent
    task automatic xreq(input string tag, input logic [31:0] a, input int hold_n,
                        input logic [31:0] ea, input logic ef, input logic en,
                        input int elat, input int erd);
        int r0, lat;
        logic busy;
        @(negedge clk); #1;
        chk(req_ready == 1'b1, {tag, " R13 idle ready"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_addr = a; r0 = rd_n; hold = hold_n;
        @(negedge clk); #1; req_valid = 1'b0; lat = 1; busy = !req_ready;
        while (!rsp_valid && lat < 40) begin @(negedge clk); #1; lat++; end
        chk(rsp_addr == ea, {tag, " addr"}, rsp_addr, ea);
        chk({rsp_fault, rsp_nia} == {ef, en}, {tag, " fault/nia"}, {30'd0, rsp_fault, rsp_nia}, {30'd0, ef, en});
        chk(lat == elat, {tag, " latency"}, 32'(lat), 32'(elat));
        chk(rd_n - r0 == erd, {tag, " reads"}, 32'(rd_n - r0), 32'(erd));
        chk(busy, {tag, " R13 busy after accept"}, 32'(busy), 32'd1);
        @(negedge clk); #1;
        chk(!rsp_valid, {tag, " R13 one-cycle rsp"}, 32'(rsp_valid), 32'd0);
    endtask

    function automatic logic [31:0] last_rd(input int back);
        return rd_log[(rd_n - back) % 16];
    endfunction

    task automatic t_reset();
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset outputs",
            {29'd0, req_ready, rsp_valid, mem_req_valid}, 32'd4);
        xreq("R1 untranslated", 32'h4000_5123, 0, 32'h4000_5123, 1'b0, 1'b1, 1, 0);
    endtask

    task automatic t_config();
        wr(5'h10, 32'h4000_0000);
        wr(5'h04, 32'h0010_0000);
        wr(5'h08, 32'h0000_0001);
        xreq("R2 xlate bit off", 32'h4000_5123, 0, 32'h4000_5123, 1'b0, 1'b1, 1, 0);
        wr(5'h02, 32'h0000_0004);
    endtask

    task automatic t_walk();
        xreq("R6 walk", 32'h4000_5123, 0, 32'hA000_5123, 1'b0, 1'b0, 5, 2);
        chk(last_rd(2) == 32'h0010_0000, "R4 dir addr", last_rd(2), 32'h0010_0000);
        chk(last_rd(1) == 32'h0020_0014, "R5 table addr", last_rd(1), 32'h0020_0014);
        xreq("R8 hit", 32'h4000_5ABC, 0, 32'hA000_5ABC, 1'b0, 1'b0, 1, 0);
    endtask

    task automatic t_window();
        xreq("R3 below base", 32'h3FFF_F000, 0, 32'h3FFF_F000, 1'b0, 1'b1, 1, 0);
        xreq("R3 at end", 32'h4200_0000, 0, 32'h4200_0000, 1'b0, 1'b1, 1, 0);
        xreq("R3 last slot", 32'h41FF_F004, 0, 32'hC03F_F004, 1'b0, 1'b0, 5, 2);
        chk(last_rd(2) == 32'h0010_001C, "R4 last dir addr", last_rd(2), 32'h0010_001C);
        chk(last_rd(1) == 32'h0040_0FFC, "R5 last table addr", last_rd(1), 32'h0040_0FFC);
        wr(5'h08, 32'h0000_0003);
        xreq("R2 R7 64MiB dir fault", 32'h4200_0000, 0, 32'h4200_0000, 1'b1, 1'b0, 3, 1);
        chk(last_rd(1) == 32'h0010_0020, "R4 slot8 addr", last_rd(1), 32'h0010_0020);
        wr(5'h08, 32'h0000_000F);
        xreq("R2 field7 empty", 32'h4000_5123, 0, 32'h4000_5123, 1'b0, 1'b1, 1, 0);
        wr(5'h08, 32'h0000_0000);
        xreq("R2 aperture off", 32'h4000_5123, 0, 32'h4000_5123, 1'b0, 1'b1, 1, 0);
        wr(5'h08, 32'h0000_0001);
    endtask

    task automatic t_fault();
        xreq("R7 table fault", 32'h4000_9000, 0, 32'h4000_9000, 1'b1, 1'b0, 5, 2);
        xreq("R7 fault not cached", 32'h4000_9000, 0, 32'h4000_9000, 1'b1, 1'b0, 5, 2);
        xreq("R7 dir fault", 32'h4080_0000, 0, 32'h4080_0000, 1'b1, 1'b0, 3, 1);
    endtask

    task automatic t_round_robin();
        wr(5'h0C, 32'h1);
        xreq("R10 flushed walks", 32'h4000_5123, 0, 32'hA000_5123, 1'b0, 1'b0, 5, 2);
        wr(5'h0C, 32'h1);
        for (int k = 0; k < 9; k++)
            xreq("R9 fill", 32'h4000_0000 + (k << 12), 0, 32'hA000_0000 + (k << 12), 1'b0, 1'b0, 5, 2);
        xreq("R9 second kept", 32'h4000_1010, 0, 32'hA000_1010, 1'b0, 1'b0, 1, 0);
        xreq("R9 first evicted", 32'h4000_0020, 0, 32'hA000_0020, 1'b0, 1'b0, 5, 2);
        wr(5'h0C, 32'h2);
        xreq("R10 bit0 clear ignored", 32'h4000_2030, 0, 32'hA000_2030, 1'b0, 1'b0, 1, 0);
        wr(5'h0C, 32'h1);
        xreq("R10 flush all", 32'h4000_2030, 0, 32'hA000_2030, 1'b0, 1'b0, 5, 2);
    endtask

    task automatic t_flush_mid();
        int lat, r0;
        @(negedge clk); #1; req_valid = 1'b1; req_addr = 32'h4041_4777; r0 = rd_n;
        @(negedge clk); #1; req_valid = 1'b0;
        reg_we = 1'b1; reg_addr = 5'h0C; reg_wdata = 32'h1;
        @(negedge clk); #1; reg_we = 1'b0; lat = 2;
        while (!rsp_valid && lat < 40) begin @(negedge clk); #1; lat++; end
        chk(rsp_addr == 32'hB001_4777, "R11 walk result", rsp_addr, 32'hB001_4777);
        chk(lat == 5, "R11 latency", 32'(lat), 32'd5);
        chk(rd_n - r0 == 2, "R11 reads", 32'(rd_n - r0), 32'd2);
        xreq("R11 not cached", 32'h4041_4000, 0, 32'hB001_4000, 1'b0, 1'b0, 5, 2);
        xreq("R11 normal fill", 32'h4041_4004, 0, 32'hB001_4004, 1'b0, 1'b0, 1, 0);
    endtask

    task automatic t_stall();
        xreq("R12 stalled ready", 32'h4001_E000, 3, 32'hA001_E000, 1'b0, 1'b0, 8, 2);
        chk(last_rd(2) == 32'h0010_0000, "R12 dir addr held", last_rd(2), 32'h0010_0000);
    endtask

    bit done = 1'b0;

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        #1; rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_config();
        t_walk();
        t_window();
        t_fault();
        t_round_robin();
        t_flush_mid();
        t_stall();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule